// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block is a cycle-level model of the management register set of one Ethernet PHY, as seen from the MAC's management frame register. The MAC side presents a 32-bit command word with a one-cycle valid strobe. The word asks to read or to write one PHY register. Exactly one cycle later the block answers with a done pulse. For a read, the register contents appear on a 16-bit response bus in that same cycle.

The model holds the basic control, status, advertisement, interrupt-source and interrupt-mask registers. It follows an external link-up input. Autonegotiation is taken to finish at once, so the link bits in the status register simply mirror the link state. Every change of link latches interrupt sources. The PHY interrupt output is raised whenever a latched source is also enabled in the mask.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the registers read control = 0x3000, status = 0x7809 with bits 2 and 5 set when link_up is high, advertisement = 0x01E1, and mask = 0. The interrupt source is 0x00C0 when the link is up and 0x0010 when it is down.
- R2: Command word fields are: bit 29 (1 = read, 0 = write), bits 27:18 (register number), and bits 15:0 (write data). Register numbers are 0 for control, 1 for status, 4 for advertisement, 29 for interrupt source and 30 for mask. A read result appears on rsp_data one cycle after cmd_valid, and rsp_data is 0 after a write.
- R3: A write to register 0 with data bit 15 clear stores data & 0x7980 into control.
- R4: A write to register 0 with data bit 15 set returns every register to its R1 value, using the current link_up level.
- R5: A write to register 30 stores data bits 7:0 as the interrupt mask. Reads of register 30 return the mask with the upper byte zero.
- R6: A read of register 29 returns the pending sources and then clears them. A link event in the same cycle is still latched after the clear.
- R7: When link_up rises, status bits 2 and 5 are set and sources bit 7 (energy on) and bit 6 (autoneg complete) are latched. When link_up falls, those status bits are cleared and source bit 4 (link down) is latched. Status follows link_up one cycle later.
- R8: Register numbers above 31 are a nonexistent PHY: reads return 0 and writes change nothing. Unlisted numbers 0 to 31 behave the same way, and status is read-only.
- R9: done_irq is high for exactly one cycle, one cycle after each accepted command, read or write.
- R10: phy_irq is high exactly when some bit is set in both the interrupt source and the mask.
- R11: A write to register 4 stores all 16 data bits into the advertisement register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word is valid this cycle |
| cmd_word | input | 32 | Management command word |
| link_up | input | 1 | External link state |
| rsp_data | output | 16 | Read result, valid with done_irq |
| done_irq | output | 1 | One-cycle management-done pulse |
| phy_irq | output | 1 | PHY interrupt request |

## Verification
A wrong source or mask bit shows on phy_irq in the cycle after the event that caused it, once the mask enables that bit. It also shows on rsp_data at the next read of register 29 or 30. A bad link-tracking state appears in the status read of the following command. A lost clear-on-read shows as stale bits on the second of two back-to-back reads of register 29. Because every register can be read back, any corruption in the register file is visible within two command cycles.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int CMD_W    = 32;
    localparam int DATA_W   = 16;
    localparam int SRC_W    = 8;
    localparam int REGN_W   = 10;
    localparam int IDX_W    = 5;
    localparam int RD_BIT   = 29;
    localparam int REGN_LSB = 18;

    localparam logic [DATA_W-1:0] CTRL_RST   = 16'h3000;
    localparam logic [DATA_W-1:0] STAT_RST   = 16'h7809;
    localparam logic [DATA_W-1:0] ADV_RST    = 16'h01E1;
    localparam logic [DATA_W-1:0] CTRL_WMASK = 16'h7980;
    localparam logic [DATA_W-1:0] STAT_LINK  = 16'h0024;
    localparam int                CTRL_RESET_BIT = 15;

    localparam logic [SRC_W-1:0] SRC_ENERGY = 8'h80;
    localparam logic [SRC_W-1:0] SRC_ANEG   = 8'h40;
    localparam logic [SRC_W-1:0] SRC_DOWN   = 8'h10;

    localparam logic [IDX_W-1:0] IDX_CTRL = 5'd0;
    localparam logic [IDX_W-1:0] IDX_STAT = 5'd1;
    localparam logic [IDX_W-1:0] IDX_ADV  = 5'd4;
    localparam logic [IDX_W-1:0] IDX_SRC  = 5'd29;
    localparam logic [IDX_W-1:0] IDX_MASK = 5'd30;

    typedef struct packed {
        logic              valid;
        logic              is_rd;
        logic              in_range;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] adv;
        logic [SRC_W-1:0]  src;
        logic [SRC_W-1:0]  mask;
        logic [DATA_W-1:0] rsp;
        logic              done;
    } regs_t;

    function automatic regs_t reset_regs(input logic link);
        regs_t r;
        r.ctrl = CTRL_RST;
        r.stat = link ? (STAT_RST | STAT_LINK) : (STAT_RST & ~STAT_LINK);
        r.adv  = ADV_RST;
        r.src  = link ? (SRC_ENERGY | SRC_ANEG) : SRC_DOWN;
        r.mask = '0;
        r.rsp  = '0;
        r.done = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
    import phy_mgmt_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output cmd_t             cmd
);
    logic [REGN_W-1:0] regn;
    logic              unused_bits;

    always_comb begin
        regn         = cmd_word[REGN_LSB +: REGN_W];
        cmd.valid    = cmd_valid;
        cmd.is_rd    = cmd_word[RD_BIT];
        cmd.in_range = (regn[REGN_W-1:IDX_W] == '0);
        cmd.idx      = regn[IDX_W-1:0];
        cmd.data     = cmd_word[DATA_W-1:0];
        unused_bits  = ^{cmd_word[CMD_W-1:RD_BIT+1], cmd_word[REGN_LSB-1:DATA_W]};
    end
endmodule

// File: rtl/phy_mgmt_link.sv
module phy_mgmt_link (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    output logic link_q,
    output logic rise,
    output logic fall
);
    logic link_d;

    always_comb begin
        link_d = link_up;
        rise   = link_up & ~link_q;
        fall   = ~link_up & link_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= link_up;
        else        link_q <= link_d;
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              link_up,
    output logic [DATA_W-1:0] rsp_data,
    output logic              done_irq,
    output logic              phy_irq
);
    cmd_t  cmd;
    regs_t q, d;
    logic  link_q, link_rise, link_fall;

    phy_mgmt_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .cmd       (cmd)
    );

    phy_mgmt_link u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .link_q  (link_q),
        .rise    (link_rise),
        .fall    (link_fall)
    );

    always_comb begin
        d      = q;
        d.done = cmd.valid;
        d.rsp  = '0;
        if (cmd.valid && cmd.in_range) begin
            if (cmd.is_rd) begin
                unique case (cmd.idx)
                    IDX_CTRL: d.rsp = q.ctrl;
                    IDX_STAT: d.rsp = q.stat;
                    IDX_ADV:  d.rsp = q.adv;
                    IDX_SRC: begin
                        d.rsp = {{(DATA_W-SRC_W){1'b0}}, q.src};
                        d.src = '0;
                    end
                    IDX_MASK: d.rsp = {{(DATA_W-SRC_W){1'b0}}, q.mask};
                    default:  d.rsp = '0;
                endcase
            end else begin
                unique case (cmd.idx)
                    IDX_CTRL: begin
                        if (cmd.data[CTRL_RESET_BIT]) begin
                            d      = reset_regs(link_up);
                            d.done = 1'b1;
                        end else begin
                            d.ctrl = cmd.data & CTRL_WMASK;
                        end
                    end
                    IDX_ADV:  d.adv  = cmd.data;
                    IDX_MASK: d.mask = cmd.data[SRC_W-1:0];
                    default:  ;
                endcase
            end
        end
        if (link_rise) begin
            d.stat = d.stat | STAT_LINK;
            d.src  = d.src | SRC_ENERGY | SRC_ANEG;
        end
        if (link_fall) begin
            d.stat = d.stat & ~STAT_LINK;
            d.src  = d.src | SRC_DOWN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= reset_regs(link_up);
        else        q <= d;
    end

    assign rsp_data = q.rsp;
    assign done_irq = q.done;
    assign phy_irq  = |(q.src & q.mask);

    a_r9_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> done_irq);
    a_r9_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !done_irq);
    a_r3_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl & ~CTRL_WMASK) == '0);
    a_r7_status_tracks_link: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stat[5] == link_q) && (q.stat[2] == link_q));
    a_r6_src_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[29] && cmd_word[27:18] == 10'd29 && (link_up == link_q))
        |=> (q.src == '0));
    a_r8_far_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_word[29] && cmd_word[27:23] != 5'd0 && (link_up == link_q))
        |=> ($stable(q.ctrl) && $stable(q.adv) && $stable(q.mask) && $stable(q.src)));
endmodule

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        link_up = 1'b0;
    logic [15:0] rsp_data;
    logic        done_irq;
    logic        phy_irq;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] m_ctrl, m_stat, m_adv;
    logic [7:0]  m_src, m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_mgmt_regs dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .link_up(link_up), .rsp_data(rsp_data), .done_irq(done_irq), .phy_irq(phy_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset(input logic link);
        m_ctrl = 16'h3000;
        m_stat = link ? 16'h782D : 16'h7809;
        m_adv  = 16'h01E1;
        m_src  = link ? 8'hC0 : 8'h10;
        m_mask = 8'h00;
    endtask

    function automatic logic [15:0] exp_read(input logic [9:0] regn);
        if (regn > 10'd31) return 16'h0;
        case (regn[4:0])
            5'd0:    return m_ctrl;
            5'd1:    return m_stat;
            5'd4:    return m_adv;
            5'd29:   return {8'h0, m_src};
            5'd30:   return {8'h0, m_mask};
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return |(m_src & m_mask);
    endfunction

    // One command; checks done (R9), data (R2), interrupt (R10).
    task automatic do_cmd(input logic rd, input logic [9:0] regn, input logic [15:0] data,
                          input string req);
        logic [15:0] exp;
        cmd_valid = 1'b1;
        cmd_word  = {2'b00, rd, 1'b0, regn, 2'b00, data};
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = $urandom;
        exp = 16'h0;
        if (rd) begin
            exp = exp_read(regn);
            if (regn == 10'd29) m_src = 8'h00;
        end else if (regn == 10'd0) begin
            if (data[15]) model_reset(link_up);
            else m_ctrl = data & 16'h7980;
        end else if (regn == 10'd4) m_adv = data;
        else if (regn == 10'd30) m_mask = data[7:0];
        check({"R9 done ", req}, {31'd0, done_irq}, 32'd1);
        check({"R2 rsp ", req}, {16'd0, rsp_data}, {16'd0, exp});
        check({"R10 irq ", req}, {31'd0, phy_irq}, {31'd0, exp_irq()});
    endtask

    task automatic set_link(input logic v);
        link_up = v;
        @(negedge clk);
        if (v && !m_stat[5]) begin m_stat |= 16'h0024; m_src |= 8'hC0; end
        if (!v && m_stat[5]) begin m_stat &= ~16'h0024; m_src |= 8'h10; end
        check("R10 irq after link change", {31'd0, phy_irq}, {31'd0, exp_irq()});
        check("R9 idle no done", {31'd0, done_irq}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset(1'b0);
        @(negedge clk);
        check("R1 done idle", {31'd0, done_irq}, 32'd0);
        check("R1 irq idle", {31'd0, phy_irq}, 32'd0);
        do_cmd(1, 10'd0, 16'h0, "R1 ctrl");
        do_cmd(1, 10'd1, 16'h0, "R1 status");
        do_cmd(1, 10'd4, 16'h0, "R1 adv");
        do_cmd(1, 10'd30, 16'h0, "R1 mask");
        do_cmd(1, 10'd29, 16'h0, "R1 src link down");
        do_cmd(1, 10'd29, 16'h0, "R6 src cleared");
        // R7 link up latches sources
        set_link(1'b1);
        do_cmd(1, 10'd1, 16'h0, "R7 status link up");
        do_cmd(0, 10'd30, 16'hFF40, "R5 mask write");
        do_cmd(1, 10'd30, 16'h0, "R5 mask readback");
        do_cmd(1, 10'd29, 16'h0, "R6 read clears");
        check("R10 irq dropped after clear", {31'd0, phy_irq}, 32'd0);
        // R7 link down
        do_cmd(0, 10'd30, 16'h0010, "R5 mask down");
        set_link(1'b0);
        check("R7 irq on link down", {31'd0, phy_irq}, 32'd1);
        do_cmd(1, 10'd1, 16'h0, "R7 status link down");
        // R3 masked control write
        do_cmd(0, 10'd0, 16'h7FFF, "R3 ctrl write");
        do_cmd(1, 10'd0, 16'h0, "R3 ctrl readback");
        // R11 advertisement
        do_cmd(0, 10'd4, 16'hBEEF, "R11 adv write");
        do_cmd(1, 10'd4, 16'h0, "R11 adv readback");
        // R8 far register and read-only status
        do_cmd(0, 10'd32, 16'h1234, "R8 far write");
        do_cmd(0, 10'd0, 16'h0000, "R8 ctrl zero");
        do_cmd(0, 10'd1023, 16'h7980, "R8 far write top");
        do_cmd(1, 10'd0, 16'h0, "R8 ctrl unchanged");
        do_cmd(0, 10'd1, 16'hFFFF, "R8 status read-only");
        do_cmd(1, 10'd1, 16'h0, "R8 status unchanged");
        do_cmd(1, 10'd33, 16'h0, "R8 far read zero");
        do_cmd(1, 10'd2, 16'h0, "R8 unlisted read zero");
        // R4 soft reset with link up
        set_link(1'b1);
        do_cmd(0, 10'd0, 16'h8000, "R4 soft reset");
        do_cmd(1, 10'd30, 16'h0, "R4 mask reset");
        do_cmd(1, 10'd4, 16'h0, "R4 adv reset");
        do_cmd(1, 10'd29, 16'h0, "R4 src after reset");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [9:0] regs [8] = '{10'd0, 10'd1, 10'd4, 10'd29, 10'd30, 10'd3, 10'd31, 10'd700};
            logic [9:0] r;
            r = regs[$urandom_range(7)];
            if ($urandom_range(9) < 2) set_link(~link_up);
            else if (r == 10'd0 && $urandom_range(3) != 0)
                do_cmd($urandom_range(1), r, $urandom & 16'h7FFF, "R2 random");
            else
                do_cmd($urandom_range(1), r, $urandom, "R2 random");
            if ($urandom_range(4) == 0) @(negedge clk);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule